// File: doc/BRIEF.md
# Instruction Single-Step Trap Generator

This block lets a debug monitor run exactly one instruction of a user program and then take control back. The monitor issues a dedicated external instruction, which is decoded into a one-cycle arm strobe. The block then counts opcode fetches, not clock cycles. It drops an active-low non-maskable interrupt request once two further fetches have occurred.

Those two fetches are the return instruction that re-enters user code and the single user instruction that follows it. The request that then appears makes the processor take the trap vector from the words at the top of memory (FFFC and FFFE), and control goes back to the monitor. Vector fetch and the monitor software are outside this block.

All state sits in one chain of flops on the system clock. The flops move forward only in cycles where the fetch strobe is high. There is one arming flop followed by `DELAY_STAGES` delay flops, with a default and minimum of two delay flops. Every flop resets to one.

Top module: `sstep_trap_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, `nmi_n` is 1 (inactive). It stays 1 through any number of fetch strobes as long as no arm strobe has been given.
- R2: `nmi_n` changes only on a clock edge where `fetch_stb` is 1. Cycles without a fetch, however many, leave `nmi_n` and any pending trap unchanged.
- R3: An arm strobe always arms the block. When `arm_stb` and `fetch_stb` are both 1 in the same cycle, the arm wins, and that fetch does not count toward the trap.
- R4: After an arm, `nmi_n` goes to 0 on the clock edge of the second fetch that comes strictly after the arm cycle (`DELAY_STAGES` = 2). After the first such fetch, `nmi_n` is still 1.
- R5: For a single arm, `nmi_n` stays 0 for exactly one fetch period. It returns to 1 on the edge of the next fetch with no other action.
- R6: If a new arm is given after the previous trap has fired, the new trap lands on the second fetch after the new arm, the same as the first. If a new arm is given one fetch after the previous arm, the two traps run together into a low period of two fetches.
- R7: Two or more arm strobes with no fetch between them produce a single trap with a low period of one fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low; sets every stage to 1 |
| fetch_stb | input | 1 | High for one clock per opcode fetch; advances all stages |
| arm_stb | input | 1 | High for one clock when the step-arm instruction is decoded |
| nmi_n | output | 1 | Non-maskable interrupt request, active low |

## Verification
The bench builds the block with the default `DELAY_STAGES` of 2. With that value, the fetch on which the trap fires is the one after the return instruction and the single user instruction. The directed scenarios reach these cases:
- an arm that coincides with a fetch;
- long stretches with no fetch, both while a trap is pending and while it is firing;
- re-arming just after a trap has fired and re-arming one fetch after an arm;
- several arms with no fetch between them.

Each case is resolved to the exact fetch on which `nmi_n` falls and the exact fetch on which it rises again.

// File: rtl/sstep_pkg.sv
package sstep_pkg;

  // Smallest delay chain that still gives the return instruction plus one
  // user instruction before the trap.
  localparam int unsigned MIN_DELAY_STAGES = 2;

  // Next value of the arming flop: an arm wins over the fetch reload.
  function automatic logic arm_next(input logic cur, input logic arm, input logic adv);
    logic nxt;
    if (arm) begin
      nxt = 1'b0;
    end else if (adv) begin
      nxt = 1'b1;
    end else begin
      nxt = cur;
    end
    return nxt;
  endfunction

  // Next value of one delay flop: it shifts only when the fetch strobe is high.
  function automatic logic stage_next(input logic cur, input logic din, input logic adv);
    return adv ? din : cur;
  endfunction

endpackage

// File: rtl/sstep_arm_stage.sv
module sstep_arm_stage
  import sstep_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_stb,
  input  logic stage_adv,
  output logic arm_level
);

  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= 1'b1;
    end else begin
      arm_q <= arm_next(arm_q, arm_stb, stage_adv);
    end
  end

  assign arm_level = arm_q;

endmodule

// File: rtl/sstep_delay_pipe.sv
module sstep_delay_pipe
  import sstep_pkg::*;
#(
  parameter int unsigned DELAY_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stage_adv,
  input  logic                    pipe_in,
  output logic [DELAY_STAGES-1:0] pipe_q
);

  for (genvar gi = 0; gi < DELAY_STAGES; gi++) begin : g_stage
    logic din;
    logic q;

    if (gi == 0) begin : g_head
      assign din = pipe_in;
    end else begin : g_link
      assign din = pipe_q[gi-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= 1'b1;
      end else begin
        q <= stage_next(q, din, stage_adv);
      end
    end

    assign pipe_q[gi] = q;
  end

endmodule

// File: rtl/sstep_trap_gen.sv
module sstep_trap_gen
  import sstep_pkg::*;
#(
  parameter int unsigned DELAY_STAGES = MIN_DELAY_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_stb,
  input  logic arm_stb,
  output logic nmi_n
);

  localparam int unsigned LAST = DELAY_STAGES - 1;

  // Named internal events, brought out for the bound checker.
  logic                    stage_adv;
  logic                    arm_level;
  logic [DELAY_STAGES-1:0] pipe_q;

  assign stage_adv = fetch_stb;

  sstep_arm_stage u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_stb   (arm_stb),
    .stage_adv (stage_adv),
    .arm_level (arm_level)
  );

  sstep_delay_pipe #(
    .DELAY_STAGES (DELAY_STAGES)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_adv (stage_adv),
    .pipe_in   (arm_level),
    .pipe_q    (pipe_q)
  );

  assign nmi_n = pipe_q[LAST];

endmodule

// File: rtl/sstep_trap_chk.sv
module sstep_trap_chk #(
  parameter int unsigned DELAY_STAGES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fetch_stb,
  input logic                    arm_stb,
  input logic                    arm_level,
  input logic [DELAY_STAGES-1:0] pipe_q,
  input logic                    nmi_n
);

  // R1: the request is inactive on the first cycle after reset is released.
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> nmi_n);

  // R2: without a fetch the request does not move.
  p_hold_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_stb |=> $stable(nmi_n));

  // R3: an arm always leaves the arming flop cleared, even when a fetch coincides.
  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_stb |=> !arm_level);

  // R3: a fetch with no arm releases the arming flop.
  p_arm_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !arm_stb) |=> arm_level);

  // R5: an isolated low pulse lasts one fetch period.
  p_nmi_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !nmi_n && pipe_q[DELAY_STAGES-2]) |=> nmi_n);

endmodule

bind sstep_trap_gen sstep_trap_chk #(
  .DELAY_STAGES (DELAY_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_stb (fetch_stb),
  .arm_stb   (arm_stb),
  .arm_level (arm_level),
  .pipe_q    (pipe_q),
  .nmi_n     (nmi_n)
);

// File: tb/sstep_trap_gen_tb.sv
`timescale 1ns/1ps
module sstep_trap_gen_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_stb = 1'b0;
  logic arm_stb = 1'b0;
  logic nmi_n;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sstep_trap_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_stb (fetch_stb),
    .arm_stb   (arm_stb),
    .nmi_n     (nmi_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic exp);
    n_run++;
    if (nmi_n !== exp) begin
      n_fail++;
      $display("FAIL %s: nmi_n act=%b exp=%b", req, nmi_n, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are sampled at the falling edge,
  // which lies after the rising edge that used them.
  task automatic fetch();
    @(negedge clk) fetch_stb = 1'b1;
    @(negedge clk) fetch_stb = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk) arm_stb = 1'b1;
    @(negedge clk) arm_stb = 1'b0;
  endtask

  task automatic arm_with_fetch();
    @(negedge clk) begin arm_stb = 1'b1; fetch_stb = 1'b1; end
    @(negedge clk) begin arm_stb = 1'b0; fetch_stb = 1'b0; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    idle(3);
    check("R1 during reset", 1'b1);
    rst_n = 1'b1;
    idle(1);
    check("R1 after release", 1'b1);
    for (int i = 0; i < 6; i++) begin
      fetch();
      check("R1 unarmed fetch", 1'b1);
    end
  endtask

  task automatic t_single();
    arm();
    check("R4 right after arm", 1'b1);
    fetch();
    check("R4 first fetch", 1'b1);
    fetch();
    check("R4 second fetch fires", 1'b0);
    idle(7);
    check("R2 low held without fetch", 1'b0);
    fetch();
    check("R5 release on next fetch", 1'b1);
    fetch();
    check("R5 stays high", 1'b1);
  endtask

  task automatic t_stall();
    arm();
    idle(40);
    check("R2 stall no trap", 1'b1);
    fetch();
    idle(25);
    check("R2 stall after one fetch", 1'b1);
    fetch();
    check("R2 fires after stall", 1'b0);
    fetch();
    check("R5 release after stall", 1'b1);
  endtask

  task automatic t_same_cycle();
    arm_with_fetch();
    check("R3 coincident fetch not counted", 1'b1);
    fetch();
    check("R3 first real fetch", 1'b1);
    fetch();
    check("R3 arm won, trap fires", 1'b0);
    fetch();
    check("R3 release", 1'b1);
  endtask

  task automatic t_rearm();
    arm(); fetch(); fetch();
    check("R6 first trap", 1'b0);
    arm();
    fetch();
    check("R6 first trap ends", 1'b1);
    fetch();
    check("R6 second trap", 1'b0);
    fetch();
    check("R6 second release", 1'b1);
    // arm one fetch after the previous arm: the low periods run together
    arm(); fetch(); arm();
    fetch();
    check("R6 adjacent arms first low", 1'b0);
    fetch();
    check("R6 adjacent arms second low", 1'b0);
    fetch();
    check("R6 adjacent arms release", 1'b1);
  endtask

  task automatic t_merge();
    arm(); idle(3); arm(); arm();
    fetch();
    check("R7 merged first fetch", 1'b1);
    fetch();
    check("R7 merged fires", 1'b0);
    fetch();
    check("R7 merged one period", 1'b1);
    fetch();
    check("R7 no second trap", 1'b1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_stall();
    t_same_cycle();
    t_rearm();
    t_merge();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule